// File: doc/BRIEF.md
# Long-Word Split Sequencer for a 16-Bit Bus

This block sits between a CPU core's operand unit and a narrow external data bus. It accepts one 32-bit operand access at a time and turns it into a series of 16-bit bus cycles. Each cycle is issued on a master port with a strobe and acknowledge handshake. When the last cycle completes, the block returns a one-cycle done pulse, the assembled 32-bit read data and the final pointer value.

The order of the 16-bit cycles depends on the kind of access:

- **Plain read or write:** upper half first, then the lower half two bytes higher.
- **Write with predecrement addressing:** the order is reversed. The lower half goes to the base minus two, then the upper half to the base minus four.
- **Clear:** a read-then-write operation. It reads both halves in ascending order, then writes zero to them in descending order.

Software-visible side effects of register writes therefore come out in a fixed, known order.

A request is taken only while the block is idle. Everything offered while it is busy is dropped.

Top module: `lw_bus_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1 and both `bus_strobe` and `rsp_done` are 0.
- R2: A write (`req_op` = 01) without predecrement drives `req_wdata[31:16]` at address A, then `req_wdata[15:0]` at A+2. A is the request address.
- R3: A write with `req_predec` = 1 drives `req_wdata[15:0]` at A-2 first, then `req_wdata[31:16]` at A-4.
- R4: A read (`req_op` = 00, or the spare code 11, which behaves as a read) first reads the effective address E, then E+2. It returns `{word at E, word at E+2}` on `rsp_rdata`. E is A, or A-4 with predecrement; the order is ascending in both cases.
- R5: A clear (`req_op` = 10) runs exactly four cycles: read E, read E+2, write 0 at E+2, write 0 at E. `rsp_rdata` holds `{word at E, word at E+2}`.
- R6: While `bus_strobe` is high and `bus_ack` is low, `bus_addr`, `bus_we` and `bus_wdata` stay unchanged and the strobe stays high.
- R7: In the clock after an acknowledged cycle, `bus_strobe` is low. The next cycle of the same access starts no earlier than that.
- R8: `rsp_done` is high for exactly one clock, the clock after the acknowledge of the last bus cycle.
- R9: `req_ready` is low from acceptance until the done pulse. A `req_valid` given then causes no bus cycle.
- R10: At the done pulse, `rsp_ptr` equals A for normal addressing and A-4 for predecrement addressing. Address arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken this clock |
| req_addr | input | AW | Base byte address |
| req_wdata | input | 32 | Long-word write data |
| req_op | input | 2 | 00 read, 01 write, 10 clear, 11 read |
| req_predec | input | 1 | Predecrement addressing |
| bus_addr | output | AW | Bus cycle address |
| bus_we | output | 1 | 1 = write cycle |
| bus_strobe | output | 1 | Bus cycle active |
| bus_wdata | output | 16 | Bus write word |
| bus_rdata | input | 16 | Bus read word |
| bus_ack | input | 1 | Cycle complete |
| rsp_done | output | 1 | Access finished (one clock) |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_ptr | output | AW | Final pointer / effective address |

## Verification
The hardest situation to reach is a request arriving while a multi-cycle access is already in progress. It matters most when the slave's wait states stretch the clear sequence across many clocks.

The stimulus covers this in two ways:

- **Busy-time requests:** a random subset of accesses raises `req_valid` again with a different address in the clock after acceptance. The bench then checks that the logged bus trace contains only the cycles of the accepted access.
- **Random wait states:** the slave model inserts zero to three wait states per cycle. This varies the distance between acknowledges and the done pulse, and exercises the stability and gap rules at every spacing.

Address wrap at both ends of the space is forced by directed cases.

// File: rtl/lw_seq_pkg.sv
package lw_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_DRIVE = 2'b01,
        ST_GAP   = 2'b10
    } seq_st_e;

    localparam logic [1:0] OP_READ  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_CLEAR = 2'b10;

    // Per-step description of one bus cycle
    typedef struct packed {
        logic upper_addr;  // address is E + one word
        logic we;          // write cycle
        logic hi_half;     // moves the upper half of the long word
        logic zero;        // write data forced to zero
        logic last;        // final cycle of the access
    } step_t;

endpackage

// File: rtl/lw_seq_step_rom.sv
module lw_seq_step_rom
    import lw_seq_pkg::*;
(
    input  logic [1:0] op,
    input  logic       predec,
    input  logic [1:0] step,
    output step_t      info
);

    always_comb begin
        info = '0;
        unique case (op)
            OP_WRITE: begin
                info.we   = 1'b1;
                info.last = (step == 2'd1);
                if (predec) begin
                    // lower half at the higher address, written first
                    info.upper_addr = (step == 2'd0);
                    info.hi_half    = (step != 2'd0);
                end else begin
                    info.upper_addr = (step != 2'd0);
                    info.hi_half    = (step == 2'd0);
                end
            end
            OP_CLEAR: begin
                info.zero = 1'b1;
                info.last = (step == 2'd3);
                case (step)
                    2'd0:    begin info.upper_addr = 1'b0; info.we = 1'b0; info.hi_half = 1'b1; end
                    2'd1:    begin info.upper_addr = 1'b1; info.we = 1'b0; info.hi_half = 1'b0; end
                    2'd2:    begin info.upper_addr = 1'b1; info.we = 1'b1; info.hi_half = 1'b0; end
                    default: begin info.upper_addr = 1'b0; info.we = 1'b1; info.hi_half = 1'b1; end
                endcase
            end
            default: begin
                // read, and the spare code, always ascending
                info.upper_addr = (step != 2'd0);
                info.hi_half    = (step == 2'd0);
                info.last       = (step == 2'd1);
            end
        endcase
    end

endmodule

// File: rtl/lw_seq_rdata.sv
module lw_seq_rdata #(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic                  cap_hi,
    input  logic [WORD_W-1:0]     word,
    output logic [2*WORD_W-1:0]   rdata
);

    localparam int LONG_W = 2 * WORD_W;

    logic [LONG_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (cap_en) begin
            if (cap_hi) rdata_d[LONG_W-1:WORD_W] = word;
            else        rdata_d[WORD_W-1:0]      = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/lw_bus_sequencer.sv
module lw_bus_sequencer
    import lw_seq_pkg::*;
#(
    parameter int AW     = 24,
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [AW-1:0]         req_addr,
    input  logic [2*WORD_W-1:0]   req_wdata,
    input  logic [1:0]            req_op,
    input  logic                  req_predec,
    output logic [AW-1:0]         bus_addr,
    output logic                  bus_we,
    output logic                  bus_strobe,
    output logic [WORD_W-1:0]     bus_wdata,
    input  logic [WORD_W-1:0]     bus_rdata,
    input  logic                  bus_ack,
    output logic                  rsp_done,
    output logic [2*WORD_W-1:0]   rsp_rdata,
    output logic [AW-1:0]         rsp_ptr
);

    localparam int             LONG_W = 2 * WORD_W;
    localparam int             BPW    = WORD_W / 8;
    localparam logic [AW-1:0]  WORD_B = AW'(BPW);
    localparam logic [AW-1:0]  LONG_B = AW'(2 * BPW);

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        step;
        logic [AW-1:0]     ea;
        logic [LONG_W-1:0] wdata;
        logic [1:0]        op;
        logic              predec;
        logic              done;
    } seq_t;

    seq_t  s_d, s_q;
    step_t cur;
    logic  drive;
    logic  cap_en;

    lw_seq_step_rom u_rom (
        .op     (s_q.op),
        .predec (s_q.predec),
        .step   (s_q.step),
        .info   (cur)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st     = ST_DRIVE;
                    s_d.step   = 2'd0;
                    s_d.ea     = req_predec ? (req_addr - LONG_B) : req_addr;
                    s_d.wdata  = req_wdata;
                    s_d.op     = req_op;
                    s_d.predec = req_predec;
                end
            end
            ST_DRIVE: begin
                if (bus_ack) begin
                    if (cur.last) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st   = ST_GAP;
                        s_d.step = s_q.step + 2'd1;
                    end
                end
            end
            ST_GAP:  s_d.st = ST_DRIVE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign drive      = (s_q.st == ST_DRIVE);
    assign bus_strobe = drive;
    assign bus_we     = cur.we;
    assign bus_addr   = cur.upper_addr ? (s_q.ea + WORD_B) : s_q.ea;
    assign bus_wdata  = cur.zero    ? '0 :
                        cur.hi_half ? s_q.wdata[LONG_W-1:WORD_W] : s_q.wdata[WORD_W-1:0];
    assign cap_en     = drive && bus_ack && !cur.we;
    assign req_ready  = (s_q.st == ST_IDLE);
    assign rsp_done   = s_q.done;
    assign rsp_ptr    = s_q.ea;

    lw_seq_rdata #(.WORD_W(WORD_W)) u_rdata (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .cap_hi (cur.hi_half),
        .word   (bus_rdata),
        .rdata  (rsp_rdata)
    );

endmodule

// File: rtl/lw_bus_sequencer_chk.sv
module lw_bus_sequencer_chk #(
    parameter int AW     = 24,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [AW-1:0]     bus_addr,
    input logic              bus_we,
    input logic              bus_strobe,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              rsp_done
);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && !bus_ack) |=> (bus_strobe && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R7
    gap_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_ack) |=> !bus_strobe);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(bus_strobe && bus_ack));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> !req_ready);

endmodule

bind lw_bus_sequencer lw_bus_sequencer_chk #(.AW(AW), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_strobe (bus_strobe),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .rsp_done   (rsp_done)
);

// File: tb/lw_bus_sequencer_test.sv
module lw_bus_sequencer_test;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [1:0]    req_op = 2'b00;
    logic          req_predec = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_we;
    logic          bus_strobe;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata = '0;
    logic          bus_ack = 1'b0;
    logic          rsp_done;
    logic [31:0]   rsp_rdata;
    logic [AW-1:0] rsp_ptr;

    always #4 clk = ~clk;

    lw_bus_sequencer #(.AW(AW), .WORD_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_op(req_op), .req_predec(req_predec),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_strobe(bus_strobe), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .rsp_ptr(rsp_ptr)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_ack_cyc = 0;

    logic [AW-1:0] lg_addr [0:7];
    logic          lg_we   [0:7];
    logic [15:0]   lg_data [0:7];
    int            lg_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return (a[15:0] * 16'd7) ^ {a[23:16], a[7:0]} ^ 16'h3C5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Slave model: random wait states, stability and gap checks
    initial begin : slave
        int unsigned   wait_left;
        bit            in_cyc;
        bit            prev_ack;
        logic [AW-1:0] h_addr;
        logic          h_we;
        logic [15:0]   h_data;
        wait_left = 0; in_cyc = 0; prev_ack = 0;
        h_addr = '0; h_we = 0; h_data = '0;
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (prev_ack) check(!bus_strobe, "R7", "strobe low after ack", 64'(bus_strobe), 64'd0);
            prev_ack = 0;
            if (bus_strobe) begin
                if (!in_cyc) begin
                    in_cyc = 1; h_addr = bus_addr; h_we = bus_we; h_data = bus_wdata;
                end
                if (wait_left == 0) begin
                    check(bus_addr == h_addr && bus_we == h_we && bus_wdata == h_data,
                          "R6", "held cycle fields", {bus_addr, bus_we, bus_wdata}, {h_addr, h_we, h_data});
                    bus_ack   = 1'b1;
                    bus_rdata = mem_word(bus_addr);
                    if (lg_n < 8) begin
                        lg_addr[lg_n] = bus_addr;
                        lg_we[lg_n]   = bus_we;
                        lg_data[lg_n] = bus_we ? bus_wdata : mem_word(bus_addr);
                    end
                    lg_n++;
                    last_ack_cyc = cyc;
                    prev_ack  = 1;
                    in_cyc    = 0;
                    wait_left = $urandom % 4;
                end else begin
                    wait_left--;
                end
            end
        end
    end

    task automatic do_op(input logic [AW-1:0] addr, input logic [31:0] data,
                         input logic [1:0] op, input bit predec, input bit poke);
        logic [AW-1:0] ea;
        logic [AW-1:0] e_addr [0:3];
        logic          e_we   [0:3];
        logic [15:0]   e_data [0:3];
        int            e_n;
        int            n;
        string         rq;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        lg_n = 0;
        req_valid = 1'b1; req_addr = addr; req_wdata = data; req_op = op; req_predec = predec;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            check(!req_ready, "R9", "ready low while busy", 64'(req_ready), 64'd0);
            req_valid = 1'b1; req_addr = addr ^ 24'h000100; req_op = 2'b01; req_predec = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!rsp_done && n < 200) begin @(negedge clk); n++; end
        check(rsp_done == 1'b1, "R8", "done seen", 64'(rsp_done), 64'd1);
        check(cyc == last_ack_cyc + 1, "R8", "done one clock after last ack",
              64'(cyc), 64'(last_ack_cyc + 1));

        ea = predec ? addr - 24'd4 : addr;
        case (op)
            2'b01: begin
                rq = predec ? "R3" : "R2";
                e_n = 2;
                if (predec) begin
                    e_addr[0] = ea + 24'd2; e_we[0] = 1; e_data[0] = data[15:0];
                    e_addr[1] = ea;         e_we[1] = 1; e_data[1] = data[31:16];
                end else begin
                    e_addr[0] = ea;         e_we[0] = 1; e_data[0] = data[31:16];
                    e_addr[1] = ea + 24'd2; e_we[1] = 1; e_data[1] = data[15:0];
                end
            end
            2'b10: begin
                rq = "R5";
                e_n = 4;
                e_addr[0] = ea;         e_we[0] = 0;
                e_addr[1] = ea + 24'd2; e_we[1] = 0;
                e_addr[2] = ea + 24'd2; e_we[2] = 1;
                e_addr[3] = ea;         e_we[3] = 1;
                e_data[0] = mem_word(e_addr[0]); e_data[1] = mem_word(e_addr[1]);
                e_data[2] = 16'h0000;            e_data[3] = 16'h0000;
            end
            default: begin
                rq = "R4";
                e_n = 2;
                e_addr[0] = ea;         e_we[0] = 0; e_data[0] = mem_word(ea);
                e_addr[1] = ea + 24'd2; e_we[1] = 0; e_data[1] = mem_word(ea + 24'd2);
            end
        endcase

        check(lg_n == e_n, (poke ? "R9" : rq), "bus cycle count", 64'(lg_n), 64'(e_n));
        for (int i = 0; i < e_n && i < lg_n; i++) begin
            check(lg_addr[i] == e_addr[i] && lg_we[i] == e_we[i] && lg_data[i] == e_data[i],
                  rq, $sformatf("cycle %0d addr/we/data", i),
                  {lg_addr[i], lg_we[i], lg_data[i]}, {e_addr[i], e_we[i], e_data[i]});
        end
        if (op != 2'b01)
            check(rsp_rdata == {mem_word(ea), mem_word(ea + 24'd2)}, rq, "assembled read data",
                  64'(rsp_rdata), 64'({mem_word(ea), mem_word(ea + 24'd2)}));
        check(rsp_ptr == ea, "R10", "final pointer", 64'(rsp_ptr), 64'(ea));
        @(negedge clk);
        check(rsp_done == 1'b0, "R8", "done is one clock", 64'(rsp_done), 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R8 actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
        check(bus_strobe == 1'b0, "R1", "strobe in reset", 64'(bus_strobe), 64'd0);
        check(rsp_done == 1'b0, "R1", "done in reset", 64'(rsp_done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && bus_strobe == 1'b0, "R1", "idle after reset",
              {req_ready, bus_strobe}, 2'b10);

        // directed corner cases
        do_op(24'hC00004, 32'h12345678, 2'b01, 1'b1, 1'b0); // R3 worked example
        do_op(24'h001000, 32'hCAFEBABE, 2'b01, 1'b0, 1'b0); // R2
        do_op(24'h000000, 32'h0, 2'b00, 1'b0, 1'b0);        // R4
        do_op(24'h000002, 32'h0, 2'b00, 1'b1, 1'b0);        // R4 predec wraps low, R10
        do_op(24'hFFFFFE, 32'hFFFFFFFF, 2'b10, 1'b0, 1'b0); // R5 wraps high
        do_op(24'h000088, 32'hFFFFFFFF, 2'b10, 1'b1, 1'b1); // R5 predec, R9 poke
        do_op(24'h004000, 32'h0, 2'b11, 1'b0, 1'b1);        // R4 spare code, R9

        for (int k = 0; k < 300; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom) & ~24'd1;
            do_op(a, $urandom, 2'($urandom % 4), 1'($urandom % 2), ($urandom % 4) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule